// File: doc/BRIEF.md
# Microcoded Multicycle Control Unit

This block is the control store and sequencer of a small 16-bit load/store processor. A micro-program counter addresses a microcode ROM of 32-bit words. Each word carries single-bit control strobes, a 4-bit ALU operation field, a flag that opens an opcode dispatch and an 8-bit next-address field. The decoded word drives the datapath's write enables, multiplexer selects and ALU function. The datapath, register file and memory sit outside this block.

Every instruction starts with two shared micro-states, FETCH (0x00) and DECODE (0x01). DECODE dispatches on the 4-bit opcode to a routine aligned on a 16-word slot. Three routines are implemented. RTYPE (opcode 1, states RT_EX 0x10 and RT_WB 0x11) runs a register-register operation. SLL (opcode 2, states SLL_EX 0x20 and SLL_WB 0x21) shifts left by one. STORE (opcode 5, states ST_EX 0x50 and ST_MEM 0x51) computes an address and writes memory. Every other opcode lands on an empty word, which returns to FETCH after one cycle.

The sequencer has three transitions. STEP loads the next-address field. RETURN is a next-address field of zero, and it goes back to FETCH. DISPATCH is taken from a word whose dispatch flag is set. Outputs are combinational from the current word and the instruction bits. The only register is the micro-PC.

Top module: `uc_control_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the micro-PC at 0x00. While reset is held, and in the first cycle after it, the outputs are those of the FETCH word.
- R2: FETCH asserts ir_we and pc_inc and steps to DECODE. DECODE drives alu_a_r0=0 (operand A is the PC), alu_b_sel=2'b01 (sign-extended offset) and alu_func=0 (add), and then dispatches.
- R3: The dispatch target is opcode×0x10 for opcodes 1 to 15, and 0xF0 for opcode 0. Opcode 1 is RTYPE, opcode 2 is SLL and opcode 5 is STORE.
- R4: A word without the dispatch flag moves to its next-address field. A field of 0x00 returns to FETCH, so each instruction ends with FETCH in the next cycle.
- R5: RT_EX drives alu_a_r0=1, alu_b_sel=2'b00 (R1) and alu_func=ir_func. RT_WB asserts rf_we with rf_wdata_mdr=0 and rf_dst_hi=0 (destination field IR[9]) and returns. alu_b_sel never reads 2'b11, and rf_we is never high together with mem_we.
- R6: SLL_EX drives alu_a_r0=1 and alu_func=8 (shift left). SLL_WB asserts rf_we with rf_dst_hi=1 (destination field IR[10]) and returns.
- R7: ST_EX drives alu_a_r0=1, alu_b_sel=2'b01 and alu_func=0. ST_MEM asserts mem_we together with mem_addr_alu and returns.
- R8: When the word's immediate-function bit is set, alu_func comes from the word's operation field. Otherwise it follows ir_func combinationally in the same cycle.
- R9: An opcode with no routine spends exactly one cycle with all strobes low and then returns to FETCH.
- R10: pc_load is high only for a word with an unconditional PC write, or for a conditional-write word while eq is high. None of the implemented words has either, so eq never raises pc_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_opcode | input | 4 | Opcode bits of the instruction register |
| ir_func | input | 4 | Function bits IR[3:0] |
| eq | input | 1 | ALU equality flag |
| ir_we | output | 1 | Instruction register write |
| pc_inc | output | 1 | Program counter increment |
| pc_load | output | 1 | Program counter load (unconditional or when eq) |
| epc_sel | output | 1 | Use the exception PC as the PC write data |
| mem_addr_alu | output | 1 | Address memory from the ALU result rather than the PC |
| mem_we | output | 1 | Memory write |
| mdr_we | output | 1 | Memory data register write |
| spc_we | output | 1 | Saved-PC register write |
| pc_from_branch | output | 1 | PC write data is the branch target rather than the jump target |
| alu_a_r0 | output | 1 | ALU operand A is R0 (else the PC) |
| alu_b_sel | output | 2 | Operand B: 00 R1, 01 sign-extended offset, 10 truncated offset |
| rf_wdata_mdr | output | 1 | Register write data comes from the MDR (else the ALU result) |
| rf_dst_hi | output | 1 | Destination register from IR[10] (else IR[9]) |
| rf_we | output | 1 | Register file write |
| alu_func | output | 4 | ALU function: 0 add, 1 sub, 2 and, 3 or, 8 sll, 9 srl |

## Verification
The awkward paths are the dispatches that do not land on a real routine. Opcode 0 must be moved to slot 0xF0 and not fall onto FETCH, and an unused opcode such as 15 shares that slot. A wrong mapping shows only as a missing or extra cycle before the next FETCH. The bench runs whole instructions back to back from a vector table and compares every port in every cycle, so a one-cycle slip breaks every later comparison. A reset is also applied in the middle of a routine. A further directed test changes ir_func and eq inside individual cycles to separate the combinational function select from the registered sequencing.

// File: rtl/uc_pkg.sv
`timescale 1ns/1ps
package uc_pkg;

    parameter int UA_W  = 8;   // micro-address width
    parameter int OP_W  = 4;   // opcode width
    parameter int FN_W  = 4;   // function field width
    parameter int UW_W  = 32;  // microword width
    parameter int ALU_W = 4;   // ALU operation field width

    localparam int SLOT_W   = UA_W - OP_W;
    localparam int ALUOP_LO = UW_W - ALU_W;

    // control bit positions inside a microword
    localparam int B_DISPATCH = 8;
    localparam int B_RF_WE    = 10;
    localparam int B_IMM      = 11;
    localparam int B_PC_INC   = 12;
    localparam int B_PC_WR    = 13;
    localparam int B_PC_COND  = 14;
    localparam int B_EPC      = 15;
    localparam int B_ADDR_ALU = 16;
    localparam int B_MEM_WE   = 17;
    localparam int B_IR_WE    = 18;
    localparam int B_MDR_WE   = 19;
    localparam int B_SPC_WE   = 20;
    localparam int B_BR_SRC   = 21;
    localparam int B_A_R0     = 22;
    localparam int B_B_SEXT   = 23;
    localparam int B_B_TRUNC  = 24;
    localparam int B_WD_MDR   = 25;
    localparam int B_DST_HI   = 27;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 4'h0,
        ALU_SUB = 4'h1,
        ALU_AND = 4'h2,
        ALU_OR  = 4'h3,
        ALU_SLL = 4'h8,
        ALU_SRL = 4'h9
    } alu_op_t;

    // named micro-states; routine entries sit at opcode * 0x10
    typedef enum logic [UA_W-1:0] {
        US_FETCH  = 8'h00,
        US_DECODE = 8'h01,
        US_RT_EX  = 8'h10,
        US_RT_WB  = 8'h11,
        US_SLL_EX = 8'h20,
        US_SLL_WB = 8'h21,
        US_ST_EX  = 8'h50,
        US_ST_MEM = 8'h51,
        US_NOP    = 8'hF0
    } ustate_t;

    typedef enum logic [1:0] {
        SEQ_STEP,
        SEQ_RETURN,
        SEQ_DISPATCH
    } seq_mode_t;

    function automatic logic [UW_W-1:0] ubit(input int pos);
        return UW_W'(1) << pos;
    endfunction

    function automatic logic [UW_W-1:0] unext(input logic [UA_W-1:0] a);
        return {{(UW_W-UA_W){1'b0}}, a};
    endfunction

    function automatic logic [UW_W-1:0] uop(input alu_op_t op);
        return {op, {ALUOP_LO{1'b0}}};
    endfunction

endpackage

// File: rtl/uc_rom.sv
`timescale 1ns/1ps
module uc_rom
    import uc_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output logic [UW_W-1:0] word
);

    always_comb begin
        unique case (addr)
            US_FETCH:  word = ubit(B_IR_WE) | ubit(B_PC_INC) | unext(US_DECODE);
            US_DECODE: word = ubit(B_IMM) | ubit(B_B_SEXT) | ubit(B_DISPATCH)
                            | uop(ALU_ADD) | unext(8'h02);
            US_RT_EX:  word = ubit(B_A_R0) | unext(US_RT_WB);
            US_RT_WB:  word = ubit(B_RF_WE) | unext(US_FETCH);
            US_SLL_EX: word = ubit(B_IMM) | ubit(B_A_R0) | uop(ALU_SLL) | unext(US_SLL_WB);
            US_SLL_WB: word = ubit(B_RF_WE) | ubit(B_DST_HI) | unext(US_FETCH);
            US_ST_EX:  word = ubit(B_IMM) | ubit(B_A_R0) | ubit(B_B_SEXT)
                            | uop(ALU_ADD) | unext(US_ST_MEM);
            US_ST_MEM: word = ubit(B_ADDR_ALU) | ubit(B_MEM_WE) | unext(US_FETCH);
            default:   word = '0;   // empty slot: no strobes, return to fetch
        endcase
    end

endmodule

// File: rtl/uc_dispatch.sv
`timescale 1ns/1ps
module uc_dispatch
    import uc_pkg::*;
#(
    parameter logic [UA_W-1:0] ZERO_OP_SLOT = 8'hF0
) (
    input  logic [OP_W-1:0] opcode,
    output logic [UA_W-1:0] target
);

    generate
        if (SLOT_W > 0) begin : g_slotted
            always_comb begin
                if (opcode == '0)
                    target = ZERO_OP_SLOT;
                else
                    target = {opcode, {SLOT_W{1'b0}}};
            end
        end else begin : g_flat
            always_comb target = (opcode == '0) ? ZERO_OP_SLOT : UA_W'(opcode);
        end
    endgenerate

endmodule

// File: rtl/uc_sequencer.sv
`timescale 1ns/1ps
module uc_sequencer
    import uc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            dispatch,
    input  logic [UA_W-1:0] next_addr,
    input  logic [UA_W-1:0] disp_target,
    output logic [UA_W-1:0] upc
);

    seq_mode_t mode;

    always_comb begin
        if (dispatch)
            mode = SEQ_DISPATCH;
        else if (next_addr == '0)
            mode = SEQ_RETURN;
        else
            mode = SEQ_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc <= US_FETCH;
        end else begin
            unique case (mode)
                SEQ_STEP:     upc <= next_addr;
                SEQ_RETURN:   upc <= US_FETCH;
                SEQ_DISPATCH: upc <= disp_target;
                default:      upc <= US_FETCH;
            endcase
        end
    end

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> upc == '0);

    assert_dispatch_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == SEQ_DISPATCH) |-> upc[3:0] == 4'h0);

    assert_return_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        mode == SEQ_RETURN |=> upc == '0);

    assert_step_next_R4: assert property (@(posedge clk) disable iff (rst)
        mode == SEQ_STEP |=> upc == $past(next_addr));

endmodule

// File: rtl/uc_decode.sv
`timescale 1ns/1ps
module uc_decode
    import uc_pkg::*;
(
    input  logic [UW_W-1:0] word,
    input  logic [FN_W-1:0] ir_func,
    input  logic            eq,
    output logic            ir_we,
    output logic            pc_inc,
    output logic            pc_load,
    output logic            epc_sel,
    output logic            mem_addr_alu,
    output logic            mem_we,
    output logic            mdr_we,
    output logic            spc_we,
    output logic            pc_from_branch,
    output logic            alu_a_r0,
    output logic [1:0]      alu_b_sel,
    output logic            rf_wdata_mdr,
    output logic            rf_dst_hi,
    output logic            rf_we,
    output logic [ALU_W-1:0] alu_func
);

    logic unused_fields;
    assign unused_fields = ^{word[UA_W-1:0], word[9], word[26], word[B_DISPATCH]};

    always_comb begin
        ir_we          = word[B_IR_WE];
        pc_inc         = word[B_PC_INC];
        pc_load        = word[B_PC_WR] | (word[B_PC_COND] & eq);
        epc_sel        = word[B_EPC];
        mem_addr_alu   = word[B_ADDR_ALU];
        mem_we         = word[B_MEM_WE];
        mdr_we         = word[B_MDR_WE];
        spc_we         = word[B_SPC_WE];
        pc_from_branch = word[B_BR_SRC];
        alu_a_r0       = word[B_A_R0];
        if (word[B_B_TRUNC])
            alu_b_sel = 2'b10;
        else if (word[B_B_SEXT])
            alu_b_sel = 2'b01;
        else
            alu_b_sel = 2'b00;
        rf_wdata_mdr   = word[B_WD_MDR];
        rf_dst_hi      = word[B_DST_HI];
        rf_we          = word[B_RF_WE];
        alu_func       = word[B_IMM] ? word[UW_W-1:ALUOP_LO] : ALU_W'(ir_func);
    end

endmodule

// File: rtl/uc_control_unit.sv
`timescale 1ns/1ps
module uc_control_unit
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  ir_opcode,
    input  logic [FN_W-1:0]  ir_func,
    input  logic             eq,
    output logic             ir_we,
    output logic             pc_inc,
    output logic             pc_load,
    output logic             epc_sel,
    output logic             mem_addr_alu,
    output logic             mem_we,
    output logic             mdr_we,
    output logic             spc_we,
    output logic             pc_from_branch,
    output logic             alu_a_r0,
    output logic [1:0]       alu_b_sel,
    output logic             rf_wdata_mdr,
    output logic             rf_dst_hi,
    output logic             rf_we,
    output logic [ALU_W-1:0] alu_func
);

    logic [UA_W-1:0] upc;
    logic [UW_W-1:0] uword;
    logic [UA_W-1:0] disp_target;

    uc_rom u_rom (
        .addr (upc),
        .word (uword)
    );

    uc_dispatch #(.ZERO_OP_SLOT(US_NOP)) u_dispatch (
        .opcode (ir_opcode),
        .target (disp_target)
    );

    uc_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .dispatch    (uword[B_DISPATCH]),
        .next_addr   (uword[UA_W-1:0]),
        .disp_target (disp_target),
        .upc         (upc)
    );

    uc_decode u_dec (
        .word           (uword),
        .ir_func        (ir_func),
        .eq             (eq),
        .ir_we          (ir_we),
        .pc_inc         (pc_inc),
        .pc_load        (pc_load),
        .epc_sel        (epc_sel),
        .mem_addr_alu   (mem_addr_alu),
        .mem_we         (mem_we),
        .mdr_we         (mdr_we),
        .spc_we         (spc_we),
        .pc_from_branch (pc_from_branch),
        .alu_a_r0       (alu_a_r0),
        .alu_b_sel      (alu_b_sel),
        .rf_wdata_mdr   (rf_wdata_mdr),
        .rf_dst_hi      (rf_dst_hi),
        .rf_we          (rf_we),
        .alu_func       (alu_func)
    );

    assert_store_addr_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr_alu);

    assert_wb_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && mem_we));

    assert_bsel_legal_R5: assert property (@(posedge clk) disable iff (rst)
        alu_b_sel != 2'b11);

    assert_fetch_after_wb_R4: assert property (@(posedge clk) disable iff (rst)
        (rf_we || mem_we) |=> (ir_we && pc_inc));

endmodule

// File: tb/uc_control_unit_test.sv
`timescale 1ns/1ps
module uc_control_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ir_opcode = 4'h0;
    logic [3:0] ir_func = 4'h0;
    logic       eq = 1'b0;
    logic ir_we, pc_inc, pc_load, epc_sel, mem_addr_alu, mem_we, mdr_we, spc_we;
    logic pc_from_branch, alu_a_r0, rf_wdata_mdr, rf_dst_hi, rf_we;
    logic [1:0] alu_b_sel;
    logic [3:0] alu_func;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uc_control_unit uut (
        .clk(clk), .rst(rst), .ir_opcode(ir_opcode), .ir_func(ir_func), .eq(eq),
        .ir_we(ir_we), .pc_inc(pc_inc), .pc_load(pc_load), .epc_sel(epc_sel),
        .mem_addr_alu(mem_addr_alu), .mem_we(mem_we), .mdr_we(mdr_we), .spc_we(spc_we),
        .pc_from_branch(pc_from_branch), .alu_a_r0(alu_a_r0), .alu_b_sel(alu_b_sel),
        .rf_wdata_mdr(rf_wdata_mdr), .rf_dst_hi(rf_dst_hi), .rf_we(rf_we),
        .alu_func(alu_func)
    );

    // {opcode, func, eq}
    localparam int NVEC = 12;
    localparam logic [8:0] VEC [NVEC] = '{
        {4'h1, 4'h3, 1'b0}, {4'h2, 4'h5, 1'b1}, {4'h5, 4'h9, 1'b0},
        {4'h0, 4'h7, 1'b1}, {4'hF, 4'h2, 1'b0}, {4'h7, 4'h1, 1'b1},
        {4'h1, 4'h9, 1'b1}, {4'h5, 4'h0, 1'b1}, {4'h3, 4'h4, 1'b0},
        {4'h2, 4'h0, 1'b0}, {4'h1, 4'h0, 1'b0}, {4'h4, 4'h6, 1'b1}
    };

    function automatic logic [18:0] observed();
        return {alu_func, ir_we, pc_inc, pc_load, epc_sel, mem_addr_alu, mem_we,
                mdr_we, spc_we, pc_from_branch, alu_a_r0, alu_b_sel,
                rf_wdata_mdr, rf_dst_hi, rf_we};
    endfunction

    function automatic bit has_routine(input logic [3:0] op);
        return (op == 4'h1) || (op == 4'h2) || (op == 4'h5);
    endfunction

    // expected port values from the requirements, step 0 = FETCH
    function automatic logic [18:0] expect_of(input logic [3:0] op, input logic [3:0] fn,
                                              input int step);
        logic [3:0] f = fn;
        logic irw = 0, pci = 0, ar0 = 0, iod = 0, mw = 0, dh = 0, rw = 0;
        logic [1:0] bs = 2'b00;
        if (step == 0) begin irw = 1; pci = 1; end                 // R2 fetch
        else if (step == 1) begin f = 4'h0; bs = 2'b01; end         // R2 decode
        else begin
            case (op)
                4'h1: if (step == 2) ar0 = 1; else rw = 1;            // R5
                4'h2: if (step == 2) begin ar0 = 1; f = 4'h8; end     // R6
                      else begin rw = 1; dh = 1; end
                4'h5: if (step == 2) begin ar0 = 1; bs = 2'b01; f = 4'h0; end // R7
                      else begin iod = 1; mw = 1; end
                default: ;                                           // R9
            endcase
        end
        return {f, irw, pci, 1'b0, 1'b0, iod, mw, 1'b0, 1'b0, 1'b0, ar0, bs,
                1'b0, dh, rw};
    endfunction

    task automatic check(input string tag, input logic [18:0] exp);
        logic [18:0] act = observed();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input int step);
        if (step == 0) return "R2/R4 fetch";
        if (step == 1) return "R2 decode";
        case (op)
            4'h1: return "R3/R5 rtype";
            4'h2: return "R3/R6 sll";
            4'h5: return "R3/R7 store";
            default: return "R3/R9 noop";
        endcase
    endfunction

    // called at a falling edge while the micro-PC sits at FETCH
    task automatic run_instr(input logic [3:0] op, input logic [3:0] fn, input logic e);
        int len = has_routine(op) ? 4 : 3;
        ir_opcode = op; ir_func = fn; eq = e;
        for (int s = 0; s < len; s++) begin
            #1 check(tag_of(op, s), expect_of(op, fn, s));
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: outputs during reset
        ir_opcode = 4'h2; ir_func = 4'h6;
        repeat (3) @(negedge clk);
        #1 check("R1 in reset", expect_of(4'h2, 4'h6, 0));
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1 first cycle", expect_of(4'h2, 4'h6, 0));

        // vector table: whole instructions back to back
        for (int i = 0; i < NVEC; i++) begin
            if (i == 0) begin
                ir_opcode = VEC[i][8:5]; ir_func = VEC[i][4:1]; eq = VEC[i][0];
                @(negedge clk);  // consume FETCH already checked above
                #1 check("R2 decode", expect_of(VEC[i][8:5], VEC[i][4:1], 1));
                @(negedge clk);
                for (int s = 2; s < 4; s++) begin
                    #1 check(tag_of(VEC[i][8:5], s), expect_of(VEC[i][8:5], VEC[i][4:1], s));
                    @(negedge clk);
                end
            end else begin
                run_instr(VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
            end
        end

        // R8: alu_func follows ir_func in FETCH, ignores it in SLL_EX
        ir_opcode = 4'h2; eq = 1'b0;
        ir_func = 4'hA; #1 check("R8 fetch func A", expect_of(4'h2, 4'hA, 0));
        ir_func = 4'h3; #1 check("R8 fetch func 3", expect_of(4'h2, 4'h3, 0));
        @(negedge clk);
        #1 check("R8 decode imm", expect_of(4'h2, 4'h3, 1));
        @(negedge clk);
        ir_func = 4'hC; #1 check("R8 sll imm", expect_of(4'h2, 4'hC, 2));
        ir_func = 4'h1; #1 check("R8 sll imm again", expect_of(4'h2, 4'h1, 2));
        @(negedge clk);
        #1 check("R6 sll wb", expect_of(4'h2, 4'h1, 3));
        @(negedge clk);

        // R10: eq toggled inside every cycle of a store never raises pc_load
        ir_opcode = 4'h5; ir_func = 4'h0;
        for (int s = 0; s < 4; s++) begin
            eq = 1'b1; #1 check("R10 eq high", expect_of(4'h5, 4'h0, s));
            eq = 1'b0; #1 check("R10 eq low", expect_of(4'h5, 4'h0, s));
            @(negedge clk);
        end

        // R1: reset in the middle of the SLL routine
        ir_opcode = 4'h2; ir_func = 4'h4;
        @(negedge clk); @(negedge clk);
        #1 check("R6 sll ex before reset", expect_of(4'h2, 4'h4, 2));
        rst = 1'b1;
        @(negedge clk);
        #1 check("R1 mid-routine reset", expect_of(4'h2, 4'h4, 0));
        rst = 1'b0;
        run_instr(4'h2, 4'h4, 1'b0);

        // R9 / R3: opcode 0 and opcode 15 both land on a one-cycle no-op
        run_instr(4'h0, 4'h5, 1'b0);
        run_instr(4'hF, 4'h5, 1'b0);
        #1 check("R4 fetch after noop", expect_of(4'h1, 4'h5, 0));

        finish_run();
    end

endmodule